// File: doc/BRIEF.md
# Staged-Expiry Watchdog Controller

This block is a watchdog counter behind a small 32-bit register bus. Software picks one of several external periodic tick lines and a period count, then starts the counter. Every rising edge of the chosen tick lowers the countdown by one. When the countdown runs out, a two-bit expiration counter advances and the countdown reloads. The first expiration raises a one-cycle early-warning interrupt. After the fourth expiration the counter halts and, if enabled, a reset request goes high and stays high until the block itself is reset.

Software keeps the system alive by repeating the start command, which reloads the countdown and clears the expiration count. Stopping the counter is guarded: the disable command takes effect only if the bus write just before it put the unlock key into the key register. The tick generators are outside this block.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, STS (offset 0x4) reads 0, CFG (offset 0x0) reads period 1, source 0 and reset-enable 0, and both `rst_req_o` and `irq_o` are low.
- R2: CFG at offset 0x0 holds the tick-source index in bits 3:0, the period count in bits 11:4 and the reset-enable flag in bit 15, and reads back what was written. A period of 0 is stored and read back as 1.
- R3: A write to CMD (offset 0x8) with bit 0 set makes the counter active, loads the countdown from the CFG period and clears the expiration count.
- R4: While active, each rising edge of the selected tick line lowers the countdown by one. Edges on tick lines that are not selected have no effect, and neither does a tick line held high.
- R5: A tick that arrives with the countdown at 1 is an expiration. The expiration count (STS bits 13:12) increments and the countdown reloads from the period, unless this is the fourth expiration.
- R6: `irq_o` is high for exactly one cycle, in the cycle after the first expiration. Later expirations do not raise it.
- R7: On the fourth expiration the counter goes inactive with countdown 0 and expiration count 3. If CFG bit 15 is set, `rst_req_o` rises and stays high, through any start or disable command, until `rst_ni` is asserted.
- R8: A start command while the counter is active acts as a keep-alive: it reloads the countdown and clears the expiration count. It takes priority over a selected tick edge in the same cycle, so that tick is neither counted nor treated as an expiration.
- R9: A CMD write with bit 1 set disables the counter and clears the countdown and expiration count. This happens only if the write immediately before it was to UNLOCK (offset 0xC) with low 16 bits 0xC45A; otherwise the disable is ignored. Each write consumes the unlock, and a write of any other key clears it. When the disable takes effect, it overrides bit 0 of the same write.
- R10: STS at offset 0x4 shows the active flag in bit 0, the countdown in bits 11:4 and the expiration count in bits 13:12. Writes to STS change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe, one per cycle |
| bus_addr_i | input | 4 | Register byte offset for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tick_i | input | NUM_TICKS | Periodic tick lines from external timers |
| rst_req_o | output | 1 | Sticky system reset request |
| irq_o | output | 1 | One-cycle early-warning pulse on the first expiration |

## Verification
The collision that matters is a keep-alive write arriving in the same clock as a selected tick edge while the countdown sits at 1. That edge would otherwise count as an expiration. The bench drives the start write and the tick edge at the same falling edge. It then expects the countdown to read back equal to the full period, the expiration count to be zero and no interrupt pulse. The unlock chain is also run with a different write placed between the key and the disable, to check that the disable is then ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [3:0] OFF_CFG = 4'h0;
  localparam logic [3:0] OFF_STS = 4'h4;
  localparam logic [3:0] OFF_CMD = 4'h8;
  localparam logic [3:0] OFF_KEY = 4'hC;

  localparam int IDX_FW  = 4;
  localparam int PER_LSB = 4;
  localparam int PER_W   = 8;
  localparam int EN_BIT  = 15;
  localparam int EXP_LSB = 12;
  localparam int EXP_W   = 2;
  localparam int KEY_W   = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hC45A;

  typedef struct packed {
    logic              rst_en;
    logic [PER_W-1:0]  period;
    logic [IDX_FW-1:0] src;
  } cfg_t;

  typedef struct packed {
    logic              active;
    logic [PER_W-1:0]  count;
    logic [EXP_W-1:0]  expc;
  } sts_t;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int NUM_TICKS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_TICKS-1:0]      tick_i,
  input  logic [wdog_pkg::IDX_FW-1:0] src_i,
  output logic                      edge_o
);
  logic [NUM_TICKS-1:0] hit;
  logic sel, sel_q;

  for (genvar g = 0; g < NUM_TICKS; g++) begin : g_hit
    assign hit[g] = tick_i[g] && (src_i == wdog_pkg::IDX_FW'(g));
  end

  assign sel    = |hit;
  assign edge_o = sel && !sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  // edge pulse never lasts two cycles
  a_r4_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  sts_t        sts_i,
  output cfg_t        cfg_o,
  output logic        start_o,
  output logic        stop_o,
  output logic [31:0] rdata_o
);
  cfg_t cfg_q;
  logic unlocked_q;
  logic cmd_wr, key_ok;
  logic [PER_W-1:0] per_wr;

  assign cmd_wr = wr_i && (addr_i == OFF_CMD);
  assign key_ok = (addr_i == OFF_KEY) && (wdata_i[KEY_W-1:0] == UNLOCK_KEY);
  assign per_wr = wdata_i[PER_LSB +: PER_W];
  assign stop_o  = cmd_wr && wdata_i[1] && unlocked_q;
  assign start_o = cmd_wr && wdata_i[0] && !stop_o;
  assign cfg_o   = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{rst_en: 1'b0, period: PER_W'(1), src: '0};
      unlocked_q <= 1'b0;
    end else if (wr_i) begin
      unlocked_q <= key_ok;
      if (addr_i == OFF_CFG) begin
        cfg_q.src    <= wdata_i[IDX_FW-1:0];
        cfg_q.period <= (per_wr == '0) ? PER_W'(1) : per_wr;
        cfg_q.rst_en <= wdata_i[EN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CFG: begin
        rdata_o[IDX_FW-1:0]         = cfg_q.src;
        rdata_o[PER_LSB +: PER_W]   = cfg_q.period;
        rdata_o[EN_BIT]             = cfg_q.rst_en;
      end
      OFF_STS: begin
        rdata_o[0]                  = sts_i.active;
        rdata_o[PER_LSB +: PER_W]   = sts_i.count;
        rdata_o[EXP_LSB +: EXP_W]   = sts_i.expc;
      end
      default: rdata_o = '0;
    endcase
  end

  a_r9_key_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_ok) |=> unlocked_q);
  a_r9_other_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !key_ok) |=> !unlocked_q);
  a_r2_period_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.period != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  cfg_t             cfg_i,
  output sts_t             sts_o,
  output logic             rst_req_o,
  output logic             irq_o
);
  localparam logic [EXP_W-1:0] EXP_LAST = '1;

  logic             active_q;
  logic [PER_W-1:0] count_q;
  logic [EXP_W-1:0] exp_q;
  logic             req_q, irq_q;
  logic             expire;

  assign expire = active_q && tick_i && (count_q <= PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      count_q  <= '0;
      exp_q    <= '0;
      req_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        active_q <= 1'b0;
        count_q  <= '0;
        exp_q    <= '0;
      end else if (start_i) begin
        active_q <= 1'b1;
        count_q  <= cfg_i.period;
        exp_q    <= '0;
      end else if (expire) begin
        if (exp_q == EXP_LAST) begin
          active_q <= 1'b0;
          count_q  <= '0;
          if (cfg_i.rst_en) req_q <= 1'b1;
        end else begin
          exp_q   <= exp_q + EXP_W'(1);
          count_q <= cfg_i.period;
          irq_q   <= (exp_q == '0);
        end
      end else if (active_q && tick_i) begin
        count_q <= count_q - PER_W'(1);
      end
    end
  end

  assign sts_o     = '{active: active_q, count: count_q, expc: exp_q};
  assign rst_req_o = req_q;
  assign irq_o     = irq_q;

  a_r3_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (active_q && exp_q == '0 && count_q == $past(cfg_i.period)));
  a_r7_req_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> req_q);
  a_r6_irq_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (exp_q == EXP_W'(1) && active_q));
  a_r4_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !tick_i) |=> $stable(count_q));
  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!active_q && count_q == '0));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int NUM_TICKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic [3:0]           bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_TICKS-1:0] tick_i,
  output logic                 rst_req_o,
  output logic                 irq_o
);
  import wdog_pkg::*;

  cfg_t cfg;
  sts_t sts;
  logic start, stop, tick_edge;

  wdog_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .sts_i   (sts),
    .cfg_o   (cfg),
    .start_o (start),
    .stop_o  (stop),
    .rdata_o (bus_rdata_o)
  );

  wdog_tick_sel #(.NUM_TICKS(NUM_TICKS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .src_i  (cfg.src),
    .edge_o (tick_edge)
  );

  wdog_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .tick_i    (tick_edge),
    .cfg_i     (cfg),
    .sts_o     (sts),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o)
  );

  a_r7_req_needs_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> !sts.active);
endmodule

// File: tb/sim_wdog_ctrl.sv
module sim_wdog_ctrl;
  localparam int NT = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [3:0] addr = 4'h4;
  logic [31:0] wdata = '0, rdata;
  logic [NT-1:0] tick = '0;
  logic rst_req, irq;
  int checks = 0, errors = 0;
  logic [31:0] smp_sts;
  logic smp_irq, smp_req;

  always #4 clk = ~clk;

  wdog_ctrl #(.NUM_TICKS(NT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_i(tick),
    .rst_req_o(rst_req), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic done;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    done();
  end

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bwr(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 4'h4; wdata = '0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 4'h4;
  endtask

  task automatic pulse(input logic [NT-1:0] m);
    tick = m;
    @(negedge clk);
    smp_sts = rdata; smp_irq = irq; smp_req = rst_req;
    tick = '0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] sts_w(input logic a, input int c, input int e);
    return {18'b0, 2'(e), 8'(c), 3'b0, a};
  endfunction

  function automatic logic [31:0] cfg_w(input int src, input int per, input logic en);
    return {16'b0, en, 3'b0, 8'(per), 4'(src)};
  endfunction

  initial begin
    logic [31:0] rv;
    @(negedge clk);
    do_reset();
    // R1 reset state
    brd(4'h4, rv); chk("R1 sts", rv, 32'h0);
    brd(4'h0, rv); chk("R1 cfg", rv, cfg_w(0, 1, 0));
    chk("R1 outputs", {30'b0, rst_req, irq}, 32'h0);

    // R2 field placement and period clamp
    bwr(4'h0, cfg_w(3, 200, 1)); brd(4'h0, rv); chk("R2 cfg readback", rv, cfg_w(3, 200, 1));
    bwr(4'h0, cfg_w(2, 0, 0));   brd(4'h0, rv); chk("R2 zero period", rv, cfg_w(2, 1, 0));

    // sweep: reset enable x source x period
    for (int en = 0; en < 2; en++) begin
      for (int src = 0; src < NT; src++) begin
        for (int per = 1; per <= 4; per++) begin
          int c, e, other;
          logic act, req;
          do_reset();
          other = (src + 1) % NT;
          bwr(4'h0, cfg_w(src, per, en[0]));
          bwr(4'h8, 32'h1);
          brd(4'h4, rv); chk("R3 start", rv, sts_w(1, per, 0));
          c = per; e = 0; act = 1; req = 0;
          for (int t = 0; t < 4 * per; t++) begin
            logic ei;
            pulse(NT'(1) << other);
            chk("R4 other tick", smp_sts, sts_w(act, c, e));
            pulse(NT'(1) << src);
            ei = 0;
            if (c == 1) begin
              if (e == 3) begin act = 0; c = 0; req = en[0]; end
              else begin ei = (e == 0); e++; c = per; end
            end else c--;
            chk(e == 3 && !act ? "R7 final expiry" : "R5 count/expire", smp_sts, sts_w(act, c, e));
            chk("R6 irq", {31'b0, smp_irq}, {31'b0, ei});
            chk("R7 rst_req", {31'b0, smp_req}, {31'b0, req});
          end
          pulse(NT'(1) << src);
          chk("R7 halted", smp_sts, sts_w(0, 0, 3));
        end
      end
    end

    // R7 sticky through start and disable
    bwr(4'h8, 32'h1);
    bwr(4'hC, 32'hC45A); bwr(4'h8, 32'h2);
    chk("R7 sticky", {31'b0, rst_req}, 32'h1);
    do_reset();
    chk("R7 cleared by reset", {31'b0, rst_req}, 32'h0);

    // R4 level held high counts once
    bwr(4'h0, cfg_w(1, 5, 0)); bwr(4'h8, 32'h1);
    tick = 4'b0010; repeat (4) @(negedge clk); tick = '0; @(negedge clk);
    brd(4'h4, rv); chk("R4 level", rv, sts_w(1, 4, 0));

    // R8 keep-alive clears expirations
    bwr(4'h0, cfg_w(1, 2, 0)); bwr(4'h8, 32'h1);
    for (int i = 0; i < 4; i++) pulse(4'b0010);
    brd(4'h4, rv); chk("R5 two expiries", rv, sts_w(1, 2, 2));
    bwr(4'h8, 32'h1);
    brd(4'h4, rv); chk("R8 keep-alive", rv, sts_w(1, 2, 0));

    // R8 keep-alive collides with expiring tick
    bwr(4'h0, cfg_w(1, 3, 0)); bwr(4'h8, 32'h1);
    pulse(4'b0010); pulse(4'b0010);
    wr = 1'b1; addr = 4'h8; wdata = 32'h1; tick = 4'b0010;
    @(negedge clk);
    wr = 1'b0; addr = 4'h4; wdata = '0;
    #1; chk("R8 collision sts", rdata, sts_w(1, 3, 0));
    chk("R8 collision irq", {31'b0, irq}, 32'h0);
    tick = '0; @(negedge clk);

    // R9 unlock protocol
    bwr(4'h8, 32'h2);
    brd(4'h4, rv); chk("R9 no key", rv[0], 1'b1);
    bwr(4'hC, 32'h1234); bwr(4'h8, 32'h2);
    brd(4'h4, rv); chk("R9 wrong key", rv[0], 1'b1);
    bwr(4'hC, 32'hC45A); bwr(4'h0, cfg_w(1, 3, 0)); bwr(4'h8, 32'h2);
    brd(4'h4, rv); chk("R9 intervening write", rv[0], 1'b1);
    bwr(4'hC, 32'hC45A); bwr(4'h8, 32'h3);
    brd(4'h4, rv); chk("R9 disabled", rv, sts_w(0, 0, 0));
    bwr(4'h8, 32'h1); bwr(4'h8, 32'h2);
    brd(4'h4, rv); chk("R9 key consumed", rv, sts_w(1, 3, 0));

    // R10 status read-only
    bwr(4'h4, 32'hFFFF_FFFF);
    brd(4'h4, rv); chk("R10 read-only", rv, sts_w(1, 3, 0));

    done();
  end
endmodule